// File: doc/BRIEF.md
# Transactional Cache Line Controller

This block is a small fully associative cache that sits beside a processor and runs short atomic transactions in hardware. The processor issues three kinds of access: a transactional load, a transactional load that claims the line for writing, and a transactional store. Every line the transaction touches is held as a pair of entries. One entry is the tentative copy: it receives stores and is thrown away if the transaction fails. The other is the backup copy: it keeps the old value and is thrown away if the transaction succeeds. A miss, or an access that needs write rights the line does not yet have, starts a transactional bus cycle. The cycle is either a shared read or a read for ownership. The bus may refuse with a busy reply.

At the end of a transaction the processor issues commit, abort or validate. Commit drops the backup copies and turns the tentative copies into ordinary committed lines. Abort does the opposite. A busy reply from the bus, or too few empty entries for a new pair, aborts the transaction at once and rolls the entries back. The transaction then stays marked as failed: every later access fails, and so do validate and commit, until commit or abort clears the mark.

Top module: `txn_line_cache`

## Requirements
- R1: After reset, no response, control completion or bus request is raised, `req_ready` is high, and a validate reports success (`ctl_ok`=1).
- R2: A load (`req_op`=0) whose address matches a tentative copy is answered one cycle after acceptance with that copy's value and `resp_ok`=1, and no bus request is made.
- R3: Any access whose address matches a committed line is served from that line without a bus cycle when the line's rights suffice. A load always has sufficient rights. The access also takes one empty entry for the backup copy.
- R4: An access that matches no line raises `bus_req_valid` in the cycle after acceptance, with `bus_req_addr` equal to the request address. `bus_req_cyc` is 0 (shared read) for a load and 1 (read for ownership) for an exclusive load (`req_op`=1) or a store (`req_op`=2). The request is held until `bus_rsp_valid` and then drops in the next cycle, when the response appears carrying the bus data for a load.
- R5: A bus reply with `bus_rsp_busy`=1 gives `resp_ok`=0 in the next cycle. Every later access also fails, with no bus request, until commit or abort.
- R6: A store writes its data into the tentative copy and returns that data. A later load of the same address in the same transaction returns the stored value.
- R7: Commit on a healthy transaction returns `ctl_ok`=1 and makes the tentative values the committed ones. Later loads of those addresses return them without a bus cycle.
- R8: Abort returns `ctl_ok`=1 and restores the backup values. Later loads return the pre-transaction value without a bus cycle.
- R9: An exclusive load or a store that hits a line held only readable issues a read-for-ownership cycle (`bus_req_cyc`=1). Once the line is held exclusively or modified, further exclusive accesses are local.
- R10: If an access needs more empty entries than exist (two for a miss, one for a committed-line hit), it fails with `resp_ok`=0 and no bus request, and the transaction is aborted.
- R11: While the transaction is marked failed, validate returns `ctl_ok`=0. Commit returns `ctl_ok`=0 and clears the mark, after which validate returns 1.
- R12: `req_ready` is low whenever a bus cycle is pending or any of `txn_commit`, `txn_abort`, `txn_validate` is high. Priority is abort, then commit, then validate. `ctl_done` pulses one cycle after a control is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor access request |
| req_ready | output | 1 | Request is taken this cycle |
| req_op | input | 2 | 0 load, 1 exclusive load, 2 store |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Store data |
| resp_valid | output | 1 | Access finished |
| resp_ok | output | 1 | 1 success, 0 transaction failed |
| resp_rdata | output | DW | Value of the line's tentative copy |
| bus_req_valid | output | 1 | Transactional bus cycle pending |
| bus_req_cyc | output | 1 | 0 shared read, 1 read for ownership |
| bus_req_addr | output | AW | Bus cycle address |
| bus_rsp_valid | input | 1 | Bus reply present |
| bus_rsp_busy | input | 1 | Bus refused the cycle |
| bus_rsp_data | input | DW | Line data from the bus |
| txn_commit | input | 1 | Commit the transaction |
| txn_abort | input | 1 | Abort the transaction |
| txn_validate | input | 1 | Ask whether the transaction is intact |
| ctl_done | output | 1 | Control result present |
| ctl_ok | output | 1 | Control result |

## Verification
Some behaviours are checked by the bound properties on every cycle. A pending bus cycle blocks new requests and keeps its address and cycle type. A bus reply ends the cycle with a response in the next cycle, and a busy reply turns into a failure. A failed transaction refuses accesses and commit, and every control is answered one cycle later. Other behaviours span several operations and are shown only by the bench's scenarios against its reference model. These are whether values return from the tentative or backup copy after commit or abort, the choice between shared and ownership cycles, the upgrade of readable lines, and the entry accounting that decides a capacity failure.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [1:0] {
    TG_EMPTY   = 2'd0,
    TG_NORMAL  = 2'd1,
    TG_XCOMMIT = 2'd2,
    TG_XABORT  = 2'd3
  } tag_e;

  typedef enum logic [1:0] {
    CS_INVALID  = 2'd0,
    CS_VALID    = 2'd1,
    CS_DIRTY    = 2'd2,
    CS_RESERVED = 2'd3
  } coh_e;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_BWAIT = 1'b1
  } fsm_e;

  typedef enum logic {
    PK_UPGRADE = 1'b0,
    PK_PAIR    = 1'b1
  } pend_e;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_LOADX = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;

  localparam logic BC_SHARED = 1'b0;
  localparam logic BC_OWN    = 1'b1;

  function automatic logic may_write(coh_e c);
    return (c == CS_DIRTY) || (c == CS_RESERVED);
  endfunction

endpackage

// File: rtl/txc_entry_bank.sv
module txc_entry_bank
  import txc_pkg::*;
#(
  parameter int NENT = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_all,
  input  logic          rollback_all,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  tag_e          wa_tag,
  input  coh_e          wa_coh,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  tag_e          wb_tag,
  input  coh_e          wb_coh,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  output tag_e          ent_tag  [NENT],
  output coh_e          ent_coh  [NENT],
  output logic [AW-1:0] ent_addr [NENT],
  output logic [DW-1:0] ent_data [NENT]
);

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    tag_e          tag_q, tag_d;
    coh_e          coh_q, coh_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          sel_a, sel_b;

    assign sel_a = wa_en && (wa_idx == IW'(g));
    assign sel_b = wb_en && (wb_idx == IW'(g));

    always_comb begin
      tag_d = tag_q;
      coh_d = coh_q;
      if (commit_all) begin
        if (tag_q == TG_XCOMMIT) begin
          tag_d = TG_EMPTY;
          coh_d = CS_INVALID;
        end else if (tag_q == TG_XABORT) begin
          tag_d = TG_NORMAL;
        end
      end
      if (rollback_all) begin
        if (tag_q == TG_XABORT) begin
          tag_d = TG_EMPTY;
          coh_d = CS_INVALID;
        end else if (tag_q == TG_XCOMMIT) begin
          tag_d = TG_NORMAL;
        end
      end
      if (sel_a) begin
        tag_d = wa_tag;
        coh_d = wa_coh;
      end else if (sel_b) begin
        tag_d = wb_tag;
        coh_d = wb_coh;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= TG_EMPTY;
        coh_q <= CS_INVALID;
      end else begin
        tag_q <= tag_d;
        coh_q <= coh_d;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_a) begin
        addr_q <= wa_addr;
        data_q <= wa_data;
      end else if (sel_b) begin
        addr_q <= wb_addr;
        data_q <= wb_data;
      end
    end

    assign ent_tag[g]  = tag_q;
    assign ent_coh[g]  = coh_q;
    assign ent_addr[g] = addr_q;
    assign ent_data[g] = data_q;
  end

endmodule

// File: rtl/txc_lookup.sv
module txc_lookup
  import txc_pkg::*;
#(
  parameter int NENT = 8,
  parameter int AW   = 32,
  parameter int IW   = 3
) (
  input  tag_e          ent_tag  [NENT],
  input  logic [AW-1:0] ent_addr [NENT],
  input  logic [AW-1:0] addr,
  output logic          hit_x,
  output logic [IW-1:0] idx_x,
  output logic          hit_n,
  output logic [IW-1:0] idx_n,
  output logic          free_a,
  output logic [IW-1:0] idx_fa,
  output logic          free_b,
  output logic [IW-1:0] idx_fb
);

  always_comb begin
    hit_x  = 1'b0;
    idx_x  = '0;
    hit_n  = 1'b0;
    idx_n  = '0;
    free_a = 1'b0;
    idx_fa = '0;
    free_b = 1'b0;
    idx_fb = '0;
    for (int i = 0; i < NENT; i++) begin
      if (!hit_x && (ent_tag[i] == TG_XABORT) && (ent_addr[i] == addr)) begin
        hit_x = 1'b1;
        idx_x = IW'(i);
      end
      if (!hit_n && (ent_tag[i] == TG_NORMAL) && (ent_addr[i] == addr)) begin
        hit_n = 1'b1;
        idx_n = IW'(i);
      end
      if (ent_tag[i] == TG_EMPTY) begin
        if (!free_a) begin
          free_a = 1'b1;
          idx_fa = IW'(i);
        end else if (!free_b) begin
          free_b = 1'b1;
          idx_fb = IW'(i);
        end
      end
    end
  end

endmodule

// File: rtl/txn_line_cache.sv
module txn_line_cache
  import txc_pkg::*;
#(
  parameter int NENT = 8,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic          resp_ok,
  output logic [DW-1:0] resp_rdata,
  output logic          bus_req_valid,
  output logic          bus_req_cyc,
  output logic [AW-1:0] bus_req_addr,
  input  logic          bus_rsp_valid,
  input  logic          bus_rsp_busy,
  input  logic [DW-1:0] bus_rsp_data,
  input  logic          txn_commit,
  input  logic          txn_abort,
  input  logic          txn_validate,
  output logic          ctl_done,
  output logic          ctl_ok
);

  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;

  // registered state
  fsm_e          st_q, st_d;
  logic          abrt_q, abrt_d;
  logic          rv_q, rv_d;
  logic          cd_q, cd_d;
  logic          bv_q, bv_d;
  logic          rok_q, rok_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          cok_q, cok_d;
  logic          bcyc_q, bcyc_d;
  logic [AW-1:0] baddr_q;
  pend_e         pk_q, pk_d;
  logic [1:0]    pop_q;
  logic [DW-1:0] pwd_q;
  logic [IW-1:0] pia_q, pia_d, pib_q, pib_d;
  logic          ld_resp, ld_ctl, ld_bus;

  // entry bank wiring
  tag_e          ent_tag  [NENT];
  coh_e          ent_coh  [NENT];
  logic [AW-1:0] ent_addr [NENT];
  logic [DW-1:0] ent_data [NENT];
  logic          commit_all, rollback_all;
  logic          wa_en, wb_en;
  logic [IW-1:0] wa_idx, wb_idx;
  tag_e          wa_tag, wb_tag;
  coh_e          wa_coh, wb_coh;
  logic [AW-1:0] wa_addr, wb_addr;
  logic [DW-1:0] wa_data, wb_data;

  logic          hit_x, hit_n, free_a, free_b;
  logic [IW-1:0] idx_x, idx_n, idx_fa, idx_fb;

  logic          ctl_any, excl, is_st, p_excl, p_st;
  coh_e          coh_x, coh_n;

  txc_entry_bank #(.NENT(NENT), .AW(AW), .DW(DW), .IW(IW)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_all   (commit_all),
    .rollback_all (rollback_all),
    .wa_en        (wa_en),
    .wa_idx       (wa_idx),
    .wa_tag       (wa_tag),
    .wa_coh       (wa_coh),
    .wa_addr      (wa_addr),
    .wa_data      (wa_data),
    .wb_en        (wb_en),
    .wb_idx       (wb_idx),
    .wb_tag       (wb_tag),
    .wb_coh       (wb_coh),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data),
    .ent_tag      (ent_tag),
    .ent_coh      (ent_coh),
    .ent_addr     (ent_addr),
    .ent_data     (ent_data)
  );

  txc_lookup #(.NENT(NENT), .AW(AW), .IW(IW)) u_look (
    .ent_tag  (ent_tag),
    .ent_addr (ent_addr),
    .addr     (req_addr),
    .hit_x    (hit_x),
    .idx_x    (idx_x),
    .hit_n    (hit_n),
    .idx_n    (idx_n),
    .free_a   (free_a),
    .idx_fa   (idx_fa),
    .free_b   (free_b),
    .idx_fb   (idx_fb)
  );

  assign ctl_any   = txn_commit || txn_abort || txn_validate;
  assign req_ready = (st_q == FS_IDLE) && !ctl_any;
  assign excl      = (req_op == OP_LOADX) || (req_op == OP_STORE);
  assign is_st     = (req_op == OP_STORE);
  assign p_excl    = (pop_q == OP_LOADX) || (pop_q == OP_STORE);
  assign p_st      = (pop_q == OP_STORE);
  assign coh_x     = ent_coh[idx_x];
  assign coh_n     = ent_coh[idx_n];

  // next-state logic
  always_comb begin
    st_d    = st_q;
    abrt_d  = abrt_q;
    rv_d    = 1'b0;
    cd_d    = 1'b0;
    bv_d    = bv_q;
    rok_d   = rok_q;
    rd_d    = rd_q;
    cok_d   = cok_q;
    bcyc_d  = bcyc_q;
    pk_d    = pk_q;
    pia_d   = pia_q;
    pib_d   = pib_q;
    ld_bus  = 1'b0;
    commit_all   = 1'b0;
    rollback_all = 1'b0;
    wa_en   = 1'b0;
    wa_idx  = '0;
    wa_tag  = TG_XABORT;
    wa_coh  = CS_VALID;
    wa_addr = req_addr;
    wa_data = req_wdata;
    wb_en   = 1'b0;
    wb_idx  = '0;
    wb_tag  = TG_XCOMMIT;
    wb_coh  = CS_VALID;
    wb_addr = req_addr;
    wb_data = req_wdata;

    if (st_q == FS_IDLE) begin
      if (txn_abort) begin
        rollback_all = 1'b1;
        abrt_d = 1'b0;
        cd_d   = 1'b1;
        cok_d  = 1'b1;
      end else if (txn_commit) begin
        cd_d = 1'b1;
        if (abrt_q) begin
          cok_d  = 1'b0;
          abrt_d = 1'b0;
        end else begin
          commit_all = 1'b1;
          cok_d      = 1'b1;
        end
      end else if (txn_validate) begin
        cd_d  = 1'b1;
        cok_d = !abrt_q;
      end else if (req_valid) begin
        if (abrt_q) begin
          rv_d  = 1'b1;
          rok_d = 1'b0;
        end else if (hit_x) begin
          if (!excl || may_write(coh_x)) begin
            wa_en   = 1'b1;
            wa_idx  = idx_x;
            wa_coh  = is_st ? CS_DIRTY : coh_x;
            wa_data = is_st ? req_wdata : ent_data[idx_x];
            rv_d    = 1'b1;
            rok_d   = 1'b1;
            rd_d    = wa_data;
          end else begin
            ld_bus = 1'b1;
            pk_d   = PK_UPGRADE;
            pia_d  = idx_x;
            bcyc_d = BC_OWN;
          end
        end else if (hit_n) begin
          if (!free_a) begin
            rollback_all = 1'b1;
            abrt_d = 1'b1;
            rv_d   = 1'b1;
            rok_d  = 1'b0;
          end else if (!excl || may_write(coh_n)) begin
            wa_en   = 1'b1;
            wa_idx  = idx_n;
            wa_coh  = is_st ? CS_DIRTY : coh_n;
            wa_data = is_st ? req_wdata : ent_data[idx_n];
            wb_en   = 1'b1;
            wb_idx  = idx_fa;
            wb_coh  = coh_n;
            wb_data = ent_data[idx_n];
            rv_d    = 1'b1;
            rok_d   = 1'b1;
            rd_d    = wa_data;
          end else begin
            ld_bus = 1'b1;
            pk_d   = PK_PAIR;
            pia_d  = idx_n;
            pib_d  = idx_fa;
            bcyc_d = BC_OWN;
          end
        end else if (!free_b) begin
          rollback_all = 1'b1;
          abrt_d = 1'b1;
          rv_d   = 1'b1;
          rok_d  = 1'b0;
        end else begin
          ld_bus = 1'b1;
          pk_d   = PK_PAIR;
          pia_d  = idx_fa;
          pib_d  = idx_fb;
          bcyc_d = excl ? BC_OWN : BC_SHARED;
        end
        if (ld_bus) begin
          st_d = FS_BWAIT;
          bv_d = 1'b1;
        end
      end
    end else if (bus_rsp_valid) begin
      st_d = FS_IDLE;
      bv_d = 1'b0;
      rv_d = 1'b1;
      if (bus_rsp_busy) begin
        rollback_all = 1'b1;
        abrt_d = 1'b1;
        rok_d  = 1'b0;
      end else begin
        wa_en   = 1'b1;
        wa_idx  = pia_q;
        wa_addr = baddr_q;
        rok_d   = 1'b1;
        if (pk_q == PK_UPGRADE) begin
          wa_coh  = p_st ? CS_DIRTY : CS_RESERVED;
          wa_data = p_st ? pwd_q : ent_data[pia_q];
        end else begin
          wa_coh  = p_st ? CS_DIRTY : (p_excl ? CS_RESERVED : CS_VALID);
          wa_data = p_st ? pwd_q : bus_rsp_data;
          wb_en   = 1'b1;
          wb_idx  = pib_q;
          wb_addr = baddr_q;
          wb_coh  = p_excl ? CS_RESERVED : CS_VALID;
          wb_data = bus_rsp_data;
        end
        rd_d = wa_data;
      end
    end
    ld_resp = rv_d;
    ld_ctl  = cd_d;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      abrt_q <= 1'b0;
      rv_q   <= 1'b0;
      cd_q   <= 1'b0;
      bv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      abrt_q <= abrt_d;
      rv_q   <= rv_d;
      cd_q   <= cd_d;
      bv_q   <= bv_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (ld_resp) begin
      rok_q <= rok_d;
      rd_q  <= rd_d;
    end
    if (ld_ctl) begin
      cok_q <= cok_d;
    end
    if (ld_bus) begin
      bcyc_q  <= bcyc_d;
      baddr_q <= req_addr;
      pk_q    <= pk_d;
      pop_q   <= req_op;
      pwd_q   <= req_wdata;
      pia_q   <= pia_d;
      pib_q   <= pib_d;
    end
  end

  assign resp_valid    = rv_q;
  assign resp_ok       = rok_q;
  assign resp_rdata    = rd_q;
  assign ctl_done      = cd_q;
  assign ctl_ok        = cok_q;
  assign bus_req_valid = bv_q;
  assign bus_req_cyc   = bcyc_q;
  assign bus_req_addr  = baddr_q;

endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          resp_ok,
  input logic          bus_req_valid,
  input logic          bus_req_cyc,
  input logic [AW-1:0] bus_req_addr,
  input logic          bus_rsp_valid,
  input logic          bus_rsp_busy,
  input logic          txn_commit,
  input logic          txn_abort,
  input logic          txn_validate,
  input logic          ctl_done,
  input logic          ctl_ok,
  input logic          abrt
);

  a_r12_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !req_ready);

  a_r4_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_rsp_valid) |=>
      (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_cyc)));

  a_r4_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_rsp_valid) |=> (!bus_req_valid && resp_valid));

  a_r5_busy_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_rsp_valid && bus_rsp_busy) |=> (resp_valid && !resp_ok));

  a_r5_sticky_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (abrt && req_valid && req_ready) |=> (resp_valid && !resp_ok && !bus_req_valid));

  a_r11_commit_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (abrt && txn_commit && !txn_abort && !bus_req_valid) |=> (ctl_done && !ctl_ok));

  a_r12_ctl_answer: assert property (@(posedge clk) disable iff (!rst_n)
    ((txn_commit || txn_abort || txn_validate) && !bus_req_valid) |=> ctl_done);

  a_r2_resp_excl_bus: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !bus_req_valid);

endmodule

bind txn_line_cache txc_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .resp_valid    (resp_valid),
  .resp_ok       (resp_ok),
  .bus_req_valid (bus_req_valid),
  .bus_req_cyc   (bus_req_cyc),
  .bus_req_addr  (bus_req_addr),
  .bus_rsp_valid (bus_rsp_valid),
  .bus_rsp_busy  (bus_rsp_busy),
  .txn_commit    (txn_commit),
  .txn_abort     (txn_abort),
  .txn_validate  (txn_validate),
  .ctl_done      (ctl_done),
  .ctl_ok        (ctl_ok),
  .abrt          (abrt_q)
);

// File: tb/sim_txn_line_cache.sv
module sim_txn_line_cache;

  localparam int CLK_PERIOD = 10;
  localparam int NENT = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          resp_valid, resp_ok;
  logic [DW-1:0] resp_rdata;
  logic          bus_req_valid, bus_req_cyc;
  logic [AW-1:0] bus_req_addr;
  logic          bus_rsp_valid, bus_rsp_busy;
  logic [DW-1:0] bus_rsp_data;
  logic          txn_commit, txn_abort, txn_validate;
  logic          ctl_done, ctl_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_line_cache #(.NENT(NENT), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_rdata(resp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cyc(bus_req_cyc), .bus_req_addr(bus_req_addr),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_busy(bus_rsp_busy), .bus_rsp_data(bus_rsp_data),
    .txn_commit(txn_commit), .txn_abort(txn_abort), .txn_validate(txn_validate),
    .ctl_done(ctl_done), .ctl_ok(ctl_ok)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";
  int    rsp_lat = 2;
  bit    rsp_busy = 1'b0;
  int    rcnt = 0;

  function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
    return a * 32'h0000_9E37 + 32'h0000_1234;
  endfunction

  // ---------------- behavioural reference model ----------------
  int            m_tag  [NENT];   // 0 empty, 1 committed, 2 backup, 3 tentative
  int            m_coh  [NENT];   // 1 readable, 2 modified, 3 exclusive
  logic [AW-1:0] m_adr  [NENT];
  logic [DW-1:0] m_dat  [NENT];
  bit            m_wait, m_fail;
  bit            mp_upg;
  logic [1:0]    mp_op;
  logic [AW-1:0] mp_adr;
  logic [DW-1:0] mp_wd;
  int            mp_a, mp_b;
  bit            e_rv, e_ok, e_cd, e_cok, e_bv, e_bcyc;
  logic [DW-1:0] e_rd;
  logic [AW-1:0] e_badr;

  function automatic int find_line(logic [AW-1:0] a, int t);
    for (int i = 0; i < NENT; i++)
      if (m_tag[i] == t && m_adr[i] == a) return i;
    return -1;
  endfunction

  function automatic int empties();
    int c = 0;
    for (int i = 0; i < NENT; i++) if (m_tag[i] == 0) c++;
    return c;
  endfunction

  function automatic int empty_from_top(int skip);
    for (int i = NENT - 1; i >= 0; i--)
      if (m_tag[i] == 0 && i != skip) return i;
    return -1;
  endfunction

  task automatic m_resolve(bit keep_tentative);
    for (int i = 0; i < NENT; i++) begin
      if (m_tag[i] == (keep_tentative ? 2 : 3)) m_tag[i] = 0;
      else if (m_tag[i] == (keep_tentative ? 3 : 2)) m_tag[i] = 1;
    end
  endtask

  task automatic m_issue(bit upg, int a, int b, bit cyc);
    m_wait = 1; mp_upg = upg; mp_a = a; mp_b = b;
    mp_op = req_op; mp_adr = req_addr; mp_wd = req_wdata;
    e_bv = 1; e_bcyc = cyc; e_badr = req_addr;
  endtask

  task automatic m_reset();
    for (int i = 0; i < NENT; i++) begin m_tag[i] = 0; m_coh[i] = 0; end
    m_wait = 0; m_fail = 0;
    e_rv = 0; e_cd = 0; e_bv = 0;
  endtask

  task automatic m_step();
    bit ex, st;
    int x, n, b;
    e_rv = 0; e_cd = 0;
    if (!m_wait) begin
      ex = (req_op == 2'd1) || (req_op == 2'd2);
      st = (req_op == 2'd2);
      if (txn_abort) begin
        m_resolve(0); m_fail = 0; e_cd = 1; e_cok = 1;
      end else if (txn_commit) begin
        e_cd = 1;
        if (m_fail) begin e_cok = 0; m_fail = 0; end
        else begin m_resolve(1); e_cok = 1; end
      end else if (txn_validate) begin
        e_cd = 1; e_cok = !m_fail;
      end else if (req_valid) begin
        x = find_line(req_addr, 3);
        n = find_line(req_addr, 1);
        if (m_fail) begin
          e_rv = 1; e_ok = 0;
        end else if (x >= 0) begin
          if (!ex || m_coh[x] >= 2) begin
            if (st) begin m_dat[x] = req_wdata; m_coh[x] = 2; end
            e_rv = 1; e_ok = 1; e_rd = m_dat[x];
          end else m_issue(1, x, -1, 1'b1);
        end else if (n >= 0) begin
          if (empties() < 1) begin
            m_resolve(0); m_fail = 1; e_rv = 1; e_ok = 0;
          end else if (!ex || m_coh[n] >= 2) begin
            b = empty_from_top(-1);
            m_tag[b] = 2; m_adr[b] = req_addr; m_dat[b] = m_dat[n]; m_coh[b] = m_coh[n];
            m_tag[n] = 3;
            if (st) begin m_dat[n] = req_wdata; m_coh[n] = 2; end
            e_rv = 1; e_ok = 1; e_rd = m_dat[n];
          end else m_issue(0, n, empty_from_top(-1), 1'b1);
        end else if (empties() < 2) begin
          m_resolve(0); m_fail = 1; e_rv = 1; e_ok = 0;
        end else begin
          b = empty_from_top(-1);
          m_issue(0, b, empty_from_top(b), ex);
        end
      end
    end else if (bus_rsp_valid) begin
      m_wait = 0; e_bv = 0; e_rv = 1;
      ex = (mp_op == 2'd1) || (mp_op == 2'd2);
      st = (mp_op == 2'd2);
      if (bus_rsp_busy) begin
        m_resolve(0); m_fail = 1; e_ok = 0;
      end else begin
        e_ok = 1;
        if (!mp_upg) begin
          m_tag[mp_b] = 2; m_adr[mp_b] = mp_adr; m_dat[mp_b] = bus_rsp_data;
          m_coh[mp_b] = ex ? 3 : 1;
          m_dat[mp_a] = bus_rsp_data;
        end
        m_tag[mp_a] = 3; m_adr[mp_a] = mp_adr;
        m_coh[mp_a] = ex ? 3 : 1;
        if (st) begin m_dat[mp_a] = mp_wd; m_coh[mp_a] = 2; end
        e_rd = m_dat[mp_a];
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  // ---------------- bus responder ----------------
  always @(negedge clk) begin
    if (bus_req_valid && !bus_rsp_valid) begin
      if (rcnt >= rsp_lat) begin
        bus_rsp_valid = 1'b1;
        bus_rsp_busy  = rsp_busy;
        bus_rsp_data  = memval(bus_req_addr);
        rcnt = 0;
      end else rcnt++;
    end else begin
      bus_rsp_valid = 1'b0;
      bus_rsp_busy  = 1'b0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    bit e_ready, bad;
    #3;
    cycles++;
    e_ready = !m_wait && !(txn_commit || txn_abort || txn_validate);
    bad = (req_ready !== e_ready) || (resp_valid !== e_rv) ||
          (ctl_done !== e_cd) || (bus_req_valid !== e_bv);
    if (e_rv && (resp_ok !== e_ok)) bad = 1;
    if (e_rv && e_ok && (resp_rdata !== e_rd)) bad = 1;
    if (e_cd && (ctl_ok !== e_cok)) bad = 1;
    if (e_bv && ((bus_req_cyc !== e_bcyc) || (bus_req_addr !== e_badr))) bad = 1;
    n_cmp++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s t=%0t act rdy=%b rv=%b ok=%b rd=%h cd=%b cok=%b bv=%b cyc=%b ba=%h | exp rdy=%b rv=%b ok=%b rd=%h cd=%b cok=%b bv=%b cyc=%b ba=%h",
               cur_req, $time, req_ready, resp_valid, resp_ok, resp_rdata, ctl_done, ctl_ok,
               bus_req_valid, bus_req_cyc, bus_req_addr,
               e_ready, e_rv, e_ok, e_rd, e_cd, e_cok, e_bv, e_bcyc, e_badr);
    end
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d cycles exp<=20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (bus_req_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic control(int kind);
    @(negedge clk);
    txn_commit = (kind == 0); txn_abort = (kind == 1); txn_validate = (kind == 2);
    @(negedge clk);
    txn_commit = 1'b0; txn_abort = 1'b0; txn_validate = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    m_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
    txn_commit = 1'b0; txn_abort = 1'b0; txn_validate = 1'b0;
    bus_rsp_valid = 1'b0; bus_rsp_busy = 1'b0; bus_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; repeat (2) @(negedge clk); control(2);

    cur_req = "R4"; access(2'd0, 32'h100, 0);
    cur_req = "R2"; access(2'd0, 32'h100, 0);
    cur_req = "R9"; access(2'd1, 32'h100, 0); access(2'd1, 32'h100, 0);
    cur_req = "R6"; access(2'd2, 32'h100, 32'hDEAD_BEEF); access(2'd0, 32'h100, 0);
    cur_req = "R7"; control(0);
    cur_req = "R3"; access(2'd0, 32'h100, 0);
    cur_req = "R7"; control(0); access(2'd0, 32'h100, 0); control(0);
    cur_req = "R8"; access(2'd2, 32'h200, 32'h0000_0055); access(2'd0, 32'h200, 0);
    control(1); access(2'd0, 32'h200, 0); control(1);
    cur_req = "R5"; rsp_busy = 1'b1; access(2'd0, 32'h300, 0);
    rsp_busy = 1'b0; access(2'd0, 32'h100, 0); access(2'd2, 32'h500, 7);
    cur_req = "R11"; control(2); control(0); control(2);
    cur_req = "R10"; rsp_lat = 0; access(2'd0, 32'h400, 0); rsp_lat = 3;
    access(2'd0, 32'h500, 0); access(2'd0, 32'h600, 0);
    access(2'd0, 32'h700, 0); control(2); control(1);
    cur_req = "R3"; access(2'd0, 32'h400, 0);
    cur_req = "R9"; access(2'd1, 32'h500, 0); access(2'd2, 32'h500, 32'h1111_2222);
    cur_req = "R12";
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 32'h600; txn_validate = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; txn_validate = 1'b0;
    repeat (2) @(negedge clk);
    control(1);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule